// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is an I2C target that gives a bus master access to an internal byte array of 8192 locations. The block runs on a fast system clock and oversamples the SCL and SDA lines. It finds start and stop conditions and decodes the device word that follows each start. It pulls SDA low only for two purposes: to acknowledge, and to return read data. SDA is open-drain, so a released line reads high.

A transfer that writes carries two memory address bytes after the device word. The first of these bytes is the high byte. Any data bytes that follow are stored at an internal pointer, which moves forward after each byte. A read returns bytes from that same pointer. A master can do a random read by setting the address in a write transfer and then issuing a repeated start with the read bit set. A write finishes inside the bus transfer itself, so the device word is never refused because of a busy state. A write-protect input blocks every change to the array. Reads work whatever the level of that input.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, `sda_oe` is 0 (SDA released). The address pointer is 0, so a read with no address phase returns location 0.
- R2: The device word is sent MSB first. Bits [7:4] must equal the type code (default 4'b1010) and bits [3:1] must equal `strap`. Bit 0 sets the direction (1 = read). On a match, SDA is held low for the whole 9th clock.
- R3: If the device word does not match, no acknowledge is given. SDA is not driven, and nothing is stored, until the next start or stop.
- R4: After a matching device word with bit 0 = 0, two address bytes follow and each is acknowledged. The pointer becomes {high[4:0], low}, and bits [7:5] of the high byte are ignored.
- R5: Each data byte in a write transfer is acknowledged and stored at the pointer. The pointer then increments, wrapping from 0x1FFF to 0x0000.
- R6: In a read, the block drives the byte at the pointer MSB first and then increments the pointer. A master acknowledge in the 9th clock asks for the next sequential byte.
- R7: A read that follows a start and a read-direction device word, with no address phase, continues from the pointer that the last write or read left.
- R8: A master not-acknowledge ends a read. SDA then stays released through any further clocks until the next start.
- R9: While `wp` is 1, data bytes are still acknowledged and the pointer still advances, but the array is not changed. Reads work the same with `wp` at either level.
- R10: A device word sent straight after the stop of a write is acknowledged. There is no busy period.
- R11: `sda_oe` only changes while the sampled SCL is low, and it is 0 after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Board-set low bits of the device address |
| wp | input | 1 | Write protect, 1 blocks all array writes |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bound checker checks a set of properties on every cycle:
- SDA only changes its drive state while SCL is low.
- The drive is released after a stop and re-armed by a start.
- SDA is driven only in an acknowledge slot or during read data, and never while the block is ignoring the bus.
- No array write happens while protect is high.
- Every stored byte moves the pointer one step past the written location.

Some behaviour only the bench scenarios can show, because it spans many bus transfers:
- The sweep of all device words against the strap.
- Data that comes back correct across sequential and random reads.
- Pointer wrap, and the upper bits of the high address byte being ignored.
- Current-address continuation.
- Silence after a master not-acknowledge.
- Discarded but acknowledged protected writes.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam int unsigned BYTE_W = 8;

    // Transfer phase of the target
    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring the bus until start
        ST_DEV,    // receiving device word
        ST_AHI,    // receiving high address byte
        ST_ALO,    // receiving low address byte
        ST_WR,     // receiving data bytes
        ST_RD      // transmitting data bytes
    } phase_e;

    // Bus events extracted from the oversampled lines
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] word,
                                       input logic [3:0] code,
                                       input logic [2:0] strap);
        return (word[7:4] == code) && (word[3:1] == strap);
    endfunction

endpackage

// File: rtl/i2c_mem_sampler.sv
module i2c_mem_sampler
    import i2c_mem_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_lvl,
    output bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_now;
    logic                   sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_now;
            sda_q    <= sda_now;
        end
    end

    assign scl_now = scl_sync[SYNC_STAGES-1];
    assign sda_now = sda_sync[SYNC_STAGES-1];
    assign scl_lvl = scl_now;

    always_comb begin
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_q;
        ev.scl_fall = ~scl_now & scl_q;
        ev.start    = scl_q & scl_now & sda_q & ~sda_now;
        ev.stop     = scl_q & scl_now & ~sda_q & sda_now;
    end

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
    import i2c_mem_pkg::*;
#(
    parameter int unsigned ADDR_W    = 13,
    parameter logic [3:0]  TYPE_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap,
    input  logic              wp,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] ptr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [BYTE_W-1:0] wdata,
    output logic              sda_oe,
    output phase_e            phase,
    output logic              in_ack
);

    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-2:0] tx_rest;
    logic              rw;
    logic              mack;
    logic [15:0]       full_addr;

    assign full_addr = {hi_q, sr};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_IDLE;
            in_ack  <= 1'b0;
            bitcnt  <= '0;
            sr      <= '0;
            hi_q    <= '0;
            tx_rest <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            ptr     <= '0;
            we      <= 1'b0;
            waddr   <= '0;
            wdata   <= '0;
            sda_oe  <= 1'b0;
        end else begin
            we <= 1'b0;
            if (ev.start) begin
                phase  <= ST_DEV;
                in_ack <= 1'b0;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                phase  <= ST_IDLE;
                in_ack <= 1'b0;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (phase == ST_RD) begin
                if (!in_ack) begin
                    if (ev.scl_fall) begin
                        if (bitcnt == LAST_TX) begin
                            in_ack <= 1'b1;
                            sda_oe <= 1'b0;
                        end else begin
                            sda_oe  <= ~tx_rest[BYTE_W-2];
                            tx_rest <= {tx_rest[BYTE_W-3:0], 1'b0};
                            bitcnt  <= bitcnt + 1'b1;
                        end
                    end
                end else begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end
                    if (ev.scl_fall) begin
                        in_ack <= 1'b0;
                        bitcnt <= '0;
                        if (mack) begin
                            sda_oe  <= ~rd_byte[BYTE_W-1];
                            tx_rest <= rd_byte[BYTE_W-2:0];
                            ptr     <= ptr + 1'b1;
                        end else begin
                            phase <= ST_IDLE;
                        end
                    end
                end
            end else if (phase != ST_IDLE) begin
                if (!in_ack) begin
                    if (ev.scl_rise) begin
                        sr     <= {sr[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (ev.scl_fall && bitcnt == LAST_RX) begin
                        case (phase)
                            ST_DEV: begin
                                if (dev_match(sr, TYPE_CODE, strap)) begin
                                    in_ack <= 1'b1;
                                    sda_oe <= 1'b1;
                                    rw     <= sr[0];
                                end else begin
                                    phase <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                hi_q   <= sr;
                                in_ack <= 1'b1;
                                sda_oe <= 1'b1;
                            end
                            ST_ALO: begin
                                ptr    <= ADDR_W'(full_addr);
                                in_ack <= 1'b1;
                                sda_oe <= 1'b1;
                            end
                            ST_WR: begin
                                in_ack <= 1'b1;
                                sda_oe <= 1'b1;
                                if (!wp) begin
                                    we    <= 1'b1;
                                    waddr <= ptr;
                                    wdata <= sr;
                                end
                                ptr <= ptr + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end else if (ev.scl_fall) begin
                    in_ack <= 1'b0;
                    bitcnt <= '0;
                    sda_oe <= 1'b0;
                    case (phase)
                        ST_DEV: begin
                            if (rw) begin
                                phase   <= ST_RD;
                                sda_oe  <= ~rd_byte[BYTE_W-1];
                                tx_rest <= rd_byte[BYTE_W-2:0];
                                ptr     <= ptr + 1'b1;
                            end else begin
                                phase <= ST_AHI;
                            end
                        end
                        ST_AHI:  phase <= ST_ALO;
                        ST_ALO:  phase <= ST_WR;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int unsigned ADDR_W      = 13,
    parameter logic [3:0]  TYPE_CODE   = 4'b1010,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap,
    input  logic       wp,
    output logic       sda_oe
);

    bus_ev_t           ev;
    logic              scl_lvl;
    logic [ADDR_W-1:0] ptr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [BYTE_W-1:0] mem_rdata;
    phase_e            phase;
    logic              in_ack;

    i2c_mem_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_lvl),
        .ev      (ev)
    );

    i2c_mem_ctrl #(.ADDR_W(ADDR_W), .TYPE_CODE(TYPE_CODE)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .strap   (strap),
        .wp      (wp),
        .rd_byte (mem_rdata),
        .ptr     (ptr),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .sda_oe  (sda_oe),
        .phase   (phase),
        .in_ack  (in_ack)
    );

    i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ptr),
        .rdata (mem_rdata)
    );

endmodule

module i2c_mem_target_chk
    import i2c_mem_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_lvl,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              sda_oe,
    input logic              wp,
    input logic              we,
    input logic [ADDR_W-1:0] waddr,
    input logic [ADDR_W-1:0] ptr,
    input phase_e            phase,
    input logic              in_ack
);

    // R11
    oe_moves_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

    // R11
    stop_frees_chk: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !sda_oe);

    // R2
    start_arms_chk: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (phase == ST_DEV && !in_ack && !sda_oe));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IDLE) |-> !sda_oe);

    // R6
    drive_window_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (in_ack || phase == ST_RD));

    // R9
    wp_guard_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> !$past(wp));

    // R5
    ptr_follows_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (ptr == waddr + ADDR_W'(1)));

endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (scl_lvl),
    .ev_start (ev.start),
    .ev_stop  (ev.stop),
    .sda_oe   (sda_oe),
    .wp       (wp),
    .we       (mem_we),
    .waddr    (mem_waddr),
    .ptr      (ptr),
    .phase    (phase),
    .in_ack   (in_ack)
);

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;

    localparam int          Q      = 4;
    localparam int          DEPTH  = 8192;
    localparam logic [2:0]  STRAP  = 3'b101;
    localparam logic [7:0]  DEV_W  = 8'hAA;
    localparam logic [7:0]  DEV_R  = 8'hAB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_mem_target uut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .strap  (STRAP),
        .wp     (wp),
        .sda_oe (sda_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'(a * 13 + salt * 29 + 5);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        wq(); sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0;
    endtask

    task automatic go_start();
        wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
    endtask

    task automatic go_stop();
        wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic tx_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic rx_byte(output logic [7:0] d, input logic more);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~more);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
        logic a;
        go_start();
        tx_byte(DEV_W, a); chk(tag, a, 1);
        tx_byte(hi, a);    chk(tag, a, 1);
        tx_byte(lo, a);    chk(tag, a, 1);
    endtask

    task automatic write_run(input logic [7:0] hi, input logic [7:0] lo,
                             input int n, input int salt, input string tag);
        logic a;
        int base;
        base = {hi[4:0], lo};
        set_addr(hi, lo, tag);
        for (int k = 0; k < n; k++) begin
            int loc;
            logic [7:0] d;
            loc = (base + k) % DEPTH;
            d = pat(loc, salt);
            tx_byte(d, a);
            chk(tag, a, 1);
            if (!wp) model[loc] = d;
        end
        go_stop();
    endtask

    task automatic read_from(input logic [7:0] hi, input logic [7:0] lo,
                             input int n, input string tag);
        logic a;
        logic [7:0] d;
        int base;
        base = {hi[4:0], lo};
        set_addr(hi, lo, tag);
        go_start();
        tx_byte(DEV_R, a); chk(tag, a, 1);
        for (int k = 0; k < n; k++) begin
            rx_byte(d, k != n - 1);
            chk(tag, d, model[(base + k) % DEPTH]);
        end
        go_stop();
    endtask

    task automatic read_cur(input int from, input int n, input string tag);
        logic a;
        logic [7:0] d;
        go_start();
        tx_byte(DEV_R, a); chk(tag, a, 1);
        for (int k = 0; k < n; k++) begin
            rx_byte(d, k != n - 1);
            chk(tag, d, model[(from + k) % DEPTH]);
        end
        go_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic a;
        logic low_seen;
        logic b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1: released after reset
        chk("R1", sda_oe, 0);

        // R1: pointer returns to 0 on reset
        write_run(8'h00, 8'h00, 4, 1, "R5");
        write_run(8'h00, 8'h10, 1, 1, "R5");
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
        read_cur(0, 1, "R1");

        // R2 / R3: sweep every type code and strap value
        for (int code = 0; code < 16; code++) begin
            for (int s = 0; s < 8; s++) begin
                int exp;
                exp = (code == 10 && s == int'(STRAP)) ? 1 : 0;
                go_start();
                tx_byte({4'(code), 3'(s), 1'b0}, a);
                go_stop();
                chk(exp == 1 ? "R2" : "R3", a, exp);
            end
        end

        // R3: bytes after a mismatched device word are ignored
        write_run(8'h00, 8'h05, 1, 2, "R5");
        go_start();
        tx_byte({4'b1010, 3'b100, 1'b0}, a); chk("R3", a, 0);
        tx_byte(8'h00, a); chk("R3", a, 0);
        tx_byte(8'h05, a); chk("R3", a, 0);
        tx_byte(8'hEE, a); chk("R3", a, 0);
        go_stop();
        read_from(8'h00, 8'h05, 1, "R3");

        // R4 / R5 / R6: sequential write and sequential read back
        write_run(8'h01, 8'h00, 32, 3, "R4");
        read_from(8'h01, 8'h00, 32, "R6");
        read_from(8'h01, 8'h11, 1, "R6");
        read_from(8'h01, 8'h07, 2, "R6");

        // R7: current-address read after a write and after a read
        write_run(8'h02, 8'h00, 8, 4, "R5");
        write_run(8'h02, 8'h00, 4, 4, "R5");
        read_cur(16'h0204, 2, "R7");
        read_cur(16'h0206, 1, "R7");

        // R5 / R4: wrap at top and ignored upper address bits
        write_run(8'hFF, 8'hFE, 3, 5, "R5");
        read_from(8'h1F, 8'hFE, 3, "R5");
        read_from(8'hE0, 8'h00, 1, "R4");

        // R9: protected writes are acknowledged, discarded, pointer advances
        wp = 1'b1;
        write_run(8'h01, 8'h00, 4, 9, "R9");
        read_cur(16'h0104, 1, "R9");
        read_from(8'h01, 8'h00, 4, "R9");
        wp = 1'b0;

        // R8: master NACK ends the read, SDA stays released
        set_addr(8'h01, 8'h00, "R8");
        go_start();
        tx_byte(DEV_R, a); chk("R8", a, 1);
        begin
            logic [7:0] d;
            rx_byte(d, 1'b0);
            chk("R8", d, model[16'h0100]);
        end
        low_seen = 1'b0;
        for (int i = 0; i < 18; i++) begin
            get_bit(b);
            if (!b) low_seen = 1'b1;
        end
        chk("R8", low_seen, 0);
        go_stop();

        // R10: device word acknowledged right after a write
        write_run(8'h03, 8'h00, 1, 6, "R10");
        go_start();
        tx_byte(DEV_W, a); chk("R10", a, 1);
        go_stop();
        // R11: released after stop
        repeat (4) @(negedge clk);
        chk("R11", sda_oe, 0);
        read_from(8'h03, 8'h00, 1, "R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule